// File: doc/BRIEF.md
# Byte-Parity Word Memory Slave

This block is a word-addressed storage slave for a simple 16-bit request bus. Every stored word carries one check bit per byte. On a write, the slave generates odd parity for each enabled byte and stores it next to the byte. On a read, it recomputes parity over both bytes and compares it with the stored bits. It reports the outcome on two status lines, `aux_lo` and `aux_hi`. All parity work stays inside the slave: the bus only sees a coded verdict, and the read data is always returned exactly as stored.

Setting `wide_mode` turns the same storage into an 18-bit data store. The two per-byte check slots then hold data bits 16 (low lane) and 17 (high lane). These bits are written from `acc_wext` and come back on `aux_lo` / `aux_hi` during the read data phase. No checking is done in this mode. A test input, `flip_par`, inverts the generated check bit of a lane on a 16-bit write, so that a bench can plant a corrupt word.

A read request (`acc_req` high, `acc_wr` low) is answered one cycle later. In that cycle `rd_valid` is high, `rd_data` holds the word, and the two status lines carry their value. In every other cycle both status lines are held low.

Top module: `parmem_slave`

## Requirements
- R1: After reset every word reads as data 0x0000 with both status lines low, because reset stores zero bytes with their odd check bit 1.
- R2: The stored check bit of a byte is 1 when the byte holds an even number of ones, and 0 otherwise. A read in 18-bit mode returns the low lane's check bit on `aux_lo` and the high lane's on `aux_hi`.
- R3: In 16-bit mode, a read of a word whose check bits match returns the stored data with `aux_lo`=0 and `aux_hi`=0.
- R4: In 16-bit mode, if either byte of the read word fails its check, the read shows `aux_lo`=0 and `aux_hi`=1, and `rd_data` still equals the stored data.
- R5: In 16-bit mode the slave never drives `aux_lo` high.
- R6: Whenever `rd_valid` is low, `aux_lo` and `aux_hi` are both low.
- R7: `acc_be` bit 0 enables the low byte (data bits 7:0) and bit 1 enables the high byte (bits 15:8). A write changes only the enabled bytes and their check slots.
- R8: In 18-bit mode, a write stores `acc_wext[0]` with the low lane and `acc_wext[1]` with the high lane, each under its byte enable, and `flip_par` has no effect. A read returns these bits on `aux_lo` / `aux_hi`.
- R9: On a 16-bit write, `flip_par[i]` inverts the generated check bit of lane i, so that a later 16-bit read reports the error code.
- R10: `rd_valid` is high in exactly the cycle after a read request, and low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = 18-bit data mode, 0 = 16-bit parity mode |
| acc_req | input | 1 | Access request for this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Word address |
| acc_be | input | 2 | Byte enables for writes (bit 0 low byte) |
| acc_wdata | input | 16 | Write data |
| acc_wext | input | 2 | Data bits 16/17 for writes in 18-bit mode |
| flip_par | input | 2 | Test: invert the generated check bit per lane |
| rd_data | output | 16 | Read data |
| rd_valid | output | 1 | Read data phase |
| aux_lo | output | 1 | Status line A / data bit 16 |
| aux_hi | output | 1 | Status line B / data bit 17 |

## Verification
The bench builds the slave with its default AW=4, which gives sixteen words. At that size it can sweep every address for the reset state, byte-enable combinations, flip patterns and 18-bit extension values. It can also drive all 256 values of a byte through the parity generator. Each byte value is read back in both modes, so the stored check bit shows up at the ports and is compared against a popcount computed in the bench.

// File: rtl/parmem_pkg.sv
// Shared lane geometry and helpers for the byte-parity memory slave.
// Assumes a two-lane, eight-bit-per-lane word.
package parmem_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    // One stored word: data plus one tag slot per lane (check bit or extra data bit)
    typedef struct packed {
        logic [LANES-1:0]  tag;
        logic [DATA_W-1:0] data;
    } word_t;

    // Odd parity bit: makes the total count of ones including itself odd
    function automatic logic odd_bit(input logic [LANE_W-1:0] b);
        return ~(^b);
    endfunction
endpackage

// File: rtl/parmem_array.sv
// Storage array: per-lane data bytes and tag slots with byte-enabled writes.
// Assumes one access per cycle. The read is combinational from rd_addr.
// Reset fills every lane with a zero byte and a tag of 1 (a valid odd word).
module parmem_array
    import parmem_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  lane_en,
    input  word_t             wr_word,
    output word_t             rd_word
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] byte_mem [DEPTH];
        logic              tag_mem  [DEPTH];

        // Lane storage: reset to zero/odd, write when this lane is enabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    byte_mem[i] <= '0;
                    tag_mem[i]  <= 1'b1;
                end
            end else if (wr_en && lane_en[l]) begin
                byte_mem[addr] <= wr_word.data[l*LANE_W +: LANE_W];
                tag_mem[addr]  <= wr_word.tag[l];
            end
        end

        // Lane read port
        always_comb begin
            rd_word.data[l*LANE_W +: LANE_W] = byte_mem[addr];
            rd_word.tag[l]                   = tag_mem[addr];
        end
    end
endmodule

// File: rtl/parmem_lane_code.sv
// Per-lane tag generator and checker.
// Write side: the tag is odd parity (optionally inverted for test), or the
// extra data bit in wide mode. Read side: flags a mismatch of stored parity.
module parmem_lane_code
    import parmem_pkg::*;
(
    input  logic              wide,
    input  logic [LANE_W-1:0] wr_byte,
    input  logic              wr_ext,
    input  logic              flip,
    output logic              wr_tag,
    input  logic [LANE_W-1:0] rd_byte,
    input  logic              rd_tag,
    output logic              mismatch
);
    // Pick the stored tag for this lane
    always_comb wr_tag = wide ? wr_ext : (odd_bit(wr_byte) ^ flip);

    // Compare recomputed parity with the stored tag
    always_comb mismatch = (odd_bit(rd_byte) != rd_tag);
endmodule

// File: rtl/parmem_status.sv
// Encodes the two bus status lines during the read data phase.
// 16-bit mode: 00 = clean, 01 = parity error (lo low, hi high); lo is never high.
// Wide mode: the lines carry the stored tag bits. Outside the data phase: 00.
module parmem_status
    import parmem_pkg::*;
(
    input  logic             phase,
    input  logic             wide,
    input  logic [LANES-1:0] mismatch,
    input  logic [LANES-1:0] tag,
    output logic             line_lo,
    output logic             line_hi
);
    // Drive the lines from mode and phase
    always_comb begin
        line_lo = 1'b0;
        line_hi = 1'b0;
        if (phase) begin
            if (wide) begin
                line_lo = tag[0];
                line_hi = tag[1];
            end else begin
                line_hi = |mismatch;
            end
        end
    end
endmodule

// File: rtl/parmem_slave.sv
// Top: byte-parity word memory slave with an 18-bit wide mode.
// A read request is answered in the next cycle. The mode is sampled with
// the request. Writes complete at the request edge.
module parmem_slave
    import parmem_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          acc_req,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_be,
    input  logic [15:0]   acc_wdata,
    input  logic [1:0]    acc_wext,
    input  logic [1:0]    flip_par,
    output logic [15:0]   rd_data,
    output logic          rd_valid,
    output logic          aux_lo,
    output logic          aux_hi
);
    word_t            wr_word;
    word_t            arr_word;
    word_t            rd_word_q;
    logic             rd_valid_q;
    logic             wide_q;
    logic [LANES-1:0] mismatch;
    logic             do_wr;
    logic             do_rd;

    // Decode the access kind
    always_comb begin
        do_wr = acc_req && acc_wr;
        do_rd = acc_req && !acc_wr;
    end

    assign wr_word.data = acc_wdata;

    for (genvar l = 0; l < LANES; l++) begin : g_code
        parmem_lane_code u_code (
            .wide     (wide_mode),
            .wr_byte  (acc_wdata[l*LANE_W +: LANE_W]),
            .wr_ext   (acc_wext[l]),
            .flip     (flip_par[l]),
            .wr_tag   (wr_word.tag[l]),
            .rd_byte  (rd_word_q.data[l*LANE_W +: LANE_W]),
            .rd_tag   (rd_word_q.tag[l]),
            .mismatch (mismatch[l])
        );
    end

    parmem_array #(.AW(AW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_wr),
        .addr    (acc_addr),
        .lane_en (acc_be),
        .wr_word (wr_word),
        .rd_word (arr_word)
    );

    // Read data phase register: word, valid flag and mode of the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word_q  <= '0;
            rd_valid_q <= 1'b0;
            wide_q     <= 1'b0;
        end else begin
            rd_valid_q <= do_rd;
            if (do_rd) begin
                rd_word_q <= arr_word;
                wide_q    <= wide_mode;
            end
        end
    end

    parmem_status u_status (
        .phase    (rd_valid_q),
        .wide     (wide_q),
        .mismatch (mismatch),
        .tag      (rd_word_q.tag),
        .line_lo  (aux_lo),
        .line_hi  (aux_hi)
    );

    assign rd_data  = rd_word_q.data;
    assign rd_valid = rd_valid_q;
endmodule

// File: rtl/parmem_chk.sv
// Protocol checker for parmem_slave, attached by bind below.
module parmem_chk #(
    parameter int AW = 4
) (
    input logic clk,
    input logic rst_n,
    input logic wide_mode,
    input logic acc_req,
    input logic acc_wr,
    input logic rd_valid,
    input logic aux_lo,
    input logic aux_hi
);
    // R6
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!aux_lo && !aux_hi));

    // R5
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_wr && !wide_mode) |=> !aux_lo);

    // R10
    read_phase_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_wr) |=> rd_valid);

    // R10
    no_phase_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !acc_wr) |=> !rd_valid);
endmodule

bind parmem_slave parmem_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .acc_req   (acc_req),
    .acc_wr    (acc_wr),
    .rd_valid  (rd_valid),
    .aux_lo    (aux_lo),
    .aux_hi    (aux_hi)
);

// File: tb/parmem_slave_bench.sv
// Self-checking sweep bench for parmem_slave at AW=4.
module parmem_slave_bench;
    localparam int  AW     = 4;
    localparam int  DEPTH  = 1 << AW;
    localparam time CLK_HP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide_mode = 1'b0;
    logic          acc_req = 1'b0;
    logic          acc_wr = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_be = 2'b00;
    logic [15:0]   acc_wdata = '0;
    logic [1:0]    acc_wext = 2'b00;
    logic [1:0]    flip_par = 2'b00;
    logic [15:0]   rd_data;
    logic          rd_valid;
    logic          aux_lo;
    logic          aux_hi;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    logic [15:0] g_d;
    logic        g_v, g_a, g_b;

    always #CLK_HP clk = ~clk;

    parmem_slave #(.AW(AW)) u_parmem_slave (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .acc_req(acc_req),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .acc_wext(acc_wext), .flip_par(flip_par),
        .rd_data(rd_data), .rd_valid(rd_valid), .aux_lo(aux_lo), .aux_hi(aux_hi)
    );

    function automatic logic odd_ref(input logic [7:0] b);
        return ($countones(b) % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [1:0] be, input logic [15:0] d,
                      input logic [1:0] ext, input logic [1:0] flip, input logic wide);
        @(negedge clk);
        wide_mode = wide; acc_req = 1'b1; acc_wr = 1'b1; acc_addr = AW'(a);
        acc_be = be; acc_wdata = d; acc_wext = ext; flip_par = flip;
        @(negedge clk);
        acc_req = 1'b0; acc_wr = 1'b0; flip_par = 2'b00;
    endtask

    task automatic rd(input int a, input logic wide);
        @(negedge clk);
        wide_mode = wide; acc_req = 1'b1; acc_wr = 1'b0; acc_addr = AW'(a);
        @(negedge clk);
        acc_req = 1'b0;
        g_d = rd_data; g_v = rd_valid; g_a = aux_lo; g_b = aux_hi;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle lines after reset", {aux_lo, aux_hi}, 2'b00);
        check("R10 no phase after reset", rd_valid, 1'b0);

        // R1: reset contents
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, 1'b0);
            check("R1 reset data", g_d, 16'h0000);
            check("R1 reset status", {g_a, g_b}, 2'b00);
            check("R10 read phase", g_v, 1'b1);
        end
        @(negedge clk);
        check("R10 phase ends", rd_valid, 1'b0);
        check("R6 lines low idle", {aux_lo, aux_hi}, 2'b00);

        // R2/R3: every byte value through both lanes, both read modes
        for (int v = 0; v < 256; v++) begin
            logic [7:0] lo = 8'(v);
            logic [7:0] hi = 8'(v) ^ 8'h3C;
            wr(v % DEPTH, 2'b11, {hi, lo}, 2'b00, 2'b00, 1'b0);
            check("R10 no phase after write", rd_valid, 1'b0);
            check("R6 lines low after write", {aux_lo, aux_hi}, 2'b00);
            rd(v % DEPTH, 1'b0);
            check("R3 clean data", g_d, {hi, lo});
            check("R3 clean status", {g_a, g_b}, 2'b00);
            rd(v % DEPTH, 1'b1);
            check("R2 stored check bits", {g_a, g_b}, {odd_ref(lo), odd_ref(hi)});
        end

        // R4/R9/R5: planted errors
        for (int a = 0; a < DEPTH; a++) begin
            logic [1:0]  f = 2'(a);
            logic [15:0] d = 16'(a * 16'h1111) ^ 16'h5A0F;
            wr(a, 2'b11, d, 2'b00, f, 1'b0);
            rd(a, 1'b0);
            check("R4 data kept on error", g_d, d);
            check("R5 line lo never high", g_a, 1'b0);
            check("R9/R4 error line", g_b, (f != 2'b00));
        end

        // R7: byte writes
        for (int a = 0; a < DEPTH; a++) begin
            logic [15:0] base = 16'hC3A5 ^ 16'(a << 4);
            wr(a, 2'b11, base, 2'b00, 2'b00, 1'b0);
            wr(a, 2'b01, 16'hFF00 | 16'(a), 2'b00, 2'b00, 1'b0);
            rd(a, 1'b0);
            check("R7 low byte write", g_d, {base[15:8], 8'(a)});
            check("R7 status after low write", {g_a, g_b}, 2'b00);
            wr(a, 2'b10, 16'h00FF | 16'((a + 7) << 8), 2'b00, 2'b00, 1'b0);
            rd(a, 1'b0);
            check("R7 high byte write", g_d, {8'(a + 7), 8'(a)});
            check("R7 status after high write", {g_a, g_b}, 2'b00);
            wr(a, 2'b00, 16'h1234, 2'b00, 2'b11, 1'b0);
            rd(a, 1'b0);
            check("R7 no lane enabled", g_d, {8'(a + 7), 8'(a)});
        end

        // R8: wide mode extra bits
        for (int a = 0; a < DEPTH; a++) begin
            for (int e = 0; e < 4; e++) begin
                logic [1:0] ev = 2'(e);
                wr(a, 2'b11, 16'(a * 257 + e), ev, 2'b11, 1'b1);
                rd(a, 1'b1);
                check("R8 wide data", g_d, 16'(a * 257 + e));
                check("R8 wide extra bits", {g_b, g_a}, ev);
                wr(a, 2'b01, 16'h0000, ~ev, 2'b00, 1'b1);
                rd(a, 1'b1);
                check("R8 wide lane write", {g_b, g_a}, {ev[1], ~ev[0]});
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule